// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block sits beside a NAND flash data bus and builds a Hamming code over every page as the words go past, without any help from software. Each word is counted only while the flash chip select is active. When the last word of the page has passed, the finished code is placed on `ecc_value`. When a page is written, the host copies that value into the spare area. When a page is read back, the host presents the stored code on `chk_ecc` with a one-cycle `chk_valid` pulse. The block XORs the stored code with the code it has just rebuilt. It then reports whether the page is clean, holds one correctable data bit (with word index and bit position), has a flipped bit in the code itself, or holds an uncorrectable error.

The snooped bus is a valid/ready stream. The block never applies back-pressure, so `bus_ready` is always high and a word counts in every cycle where `bus_valid` and `bus_cs` are both high. A master that holds `bus_valid` high sees each cycle as a new word. Configuration, check and status pins are plain levels or single-cycle pulses.

Top module: `nand_hamming_ecc`

## Requirements
- R1: A word is taken only in a cycle where both `bus_valid` and `bus_cs` are high. Words seen with `bus_cs` low change neither the code nor the word count.
- R2: The page length in words is (512 << `cfg_page`) bytes divided by 1 in 8-bit mode or by 2 in 16-bit mode. `cfg_page` values 0, 1, 2 and 3 select 512, 1024, 2048 and 4096 bytes. In the cycle after the last word of a page, `ecc_value` holds that page's code and `page_done` is high. The word index then wraps to 0, so further words start a new page.
- R3: The 32-bit code has four fields. Bits [11:0] are line parity over the words whose index bit i is 1, and bits [23:12] cover the words whose index bit i is 0. Bits [27:24] are column parity over the data bits whose position bit j is 1, and bits [31:28] cover the data bits whose position bit j is 0.
- R4: When `cfg_wide` is 1 the bus is 16 bits wide. When it is 0 the bus is 8 bits wide and `bus_data[15:8]` has no effect on the code.
- R5: A `sw_clr` pulse discards the partial page: parity and the word index return to zero, and a word in the same cycle is dropped.
- R6: A check whose syndrome (stored code XOR last page code) is zero leaves all error fields at zero.
- R7: A syndrome in which each true/complement pair differs in every bit is a single data-bit error. It sets `err_flag` and `corr_flag`, with `err_word` = syndrome[11:0] and `err_bit` = syndrome[27:24].
- R8: A syndrome with exactly one bit set is an error in the stored code. It sets `err_flag`, `corr_flag` and `ecc_err`, and leaves `err_word` and `err_bit` at zero.
- R9: Any other nonzero syndrome sets `err_flag` with `corr_flag` low.
- R10: Status flags are sticky. The first error report is held against later checks until `stat_rd` is pulsed, and the flags are clear in the cycle after that pulse. A check in the same cycle as `stat_rd` is recorded. `page_done` is also cleared by `stat_rd`, but a page completing in that same cycle sets it again.
- R11: While `rst_n` is low, every output except `bus_ready` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A word is on the snooped bus |
| bus_ready | output | 1 | Always high; the snooper never stalls |
| bus_data | input | 16 | Snooped data word |
| bus_cs | input | 1 | Flash chip select, active high |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_page | input | 2 | Page size select, 0..3 = 512..4096 bytes |
| sw_clr | input | 1 | Discard the partial page |
| chk_valid | input | 1 | Pulse: compare `chk_ecc` with the last page code |
| chk_ecc | input | 32 | Stored code read from the spare area |
| stat_rd | input | 1 | Pulse: status read, clears sticky flags |
| ecc_value | output | 32 | Code of the last completed page |
| page_done | output | 1 | A page has completed since the last status read |
| err_flag | output | 1 | An error was found |
| corr_flag | output | 1 | The recorded error is correctable |
| ecc_err | output | 1 | The recorded error lies in the stored code |
| err_word | output | 12 | Index of the failing word |
| err_bit | output | 4 | Bit position of the failing bit |

## Verification
The hardest case to reach from the ports is a single flipped bit at the very last word and highest bit of the largest page, in both bus widths. That word is where the word index wraps and where the line-parity fields carry their highest index bits. The bench first passes a clean page to obtain a reference code. It then sends the same page again with one bit inverted and presents the reference code, so the rebuilt code is what differs from the stored one. The sticky hold is also covered: a second faulty page is checked while an earlier error report is still pending.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  typedef enum logic [1:0] {
    SYN_CLEAN = 2'd0,
    SYN_DATA  = 2'd1,
    SYN_CODE  = 2'd2,
    SYN_MULTI = 2'd3
  } syn_kind_e;

  // words in one page for a given size select and bus width
  function automatic int unsigned page_words(input logic [1:0] sel,
                                             input logic wide,
                                             input int unsigned min_bytes);
    int unsigned bytes;
    bytes = min_bytes << sel;
    return wide ? (bytes >> 1) : bytes;
  endfunction

endpackage

// File: rtl/nand_ecc_wordctr.sv
module nand_ecc_wordctr #(
  parameter int IDX_W     = 12,
  parameter int MIN_BYTES = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sw_clr,
  input  logic [1:0]       cfg_page,
  input  logic             cfg_wide,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam int CNT_W = IDX_W + 1;

  logic [CNT_W-1:0] span;

  always_comb span = CNT_W'(nand_ecc_pkg::page_words(cfg_page, cfg_wide, MIN_BYTES));

  assign last = ({1'b0, idx} == (span - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (sw_clr) idx <= '0;
    else if (beat)   idx <= last ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/nand_ecc_parity.sv
module nand_ecc_parity #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 12,
  parameter int BIT_W  = 4,
  parameter int ECC_W  = 2 * (IDX_W + BIT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              wrap,
  input  logic              sw_clr,
  input  logic              cfg_wide,
  input  logic [DATA_W-1:0] data,
  input  logic [IDX_W-1:0]  idx,
  output logic [ECC_W-1:0]  acc_next
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] dm;
  logic              wpar;
  logic [IDX_W-1:0]  line_t, line_c;
  logic [BIT_W-1:0]  col_t, col_c;
  logic [ECC_W-1:0]  acc;

  always_comb dm = cfg_wide ? data : {{HALF{1'b0}}, data[HALF-1:0]};
  assign wpar = ^dm;

  for (genvar i = 0; i < IDX_W; i++) begin : g_line
    assign line_t[i] = idx[i] & wpar;
    assign line_c[i] = ~idx[i] & wpar;
  end

  for (genvar j = 0; j < BIT_W; j++) begin : g_col
    logic [DATA_W-1:0] pick;
    for (genvar b = 0; b < DATA_W; b++) begin : g_b
      assign pick[b] = ((b >> j) & 1) != 0;
    end
    assign col_t[j] = ^(dm & pick);
    assign col_c[j] = ^(dm & ~pick);
  end

  assign acc_next = acc ^ {col_c, col_t, line_c, line_t};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (sw_clr) acc <= '0;
    else if (beat)   acc <= wrap ? '0 : acc_next;
  end
endmodule

// File: rtl/nand_ecc_decode.sv
module nand_ecc_decode
  import nand_ecc_pkg::*;
#(
  parameter int IDX_W = 12,
  parameter int BIT_W = 4,
  parameter int ECC_W = 2 * (IDX_W + BIT_W)
) (
  input  logic [ECC_W-1:0] stored,
  input  logic [ECC_W-1:0] computed,
  output syn_kind_e        kind,
  output logic [IDX_W-1:0] word,
  output logic [BIT_W-1:0] bitpos
);
  logic [ECC_W-1:0] syn;
  logic [IDX_W-1:0] lt, lc;
  logic [BIT_W-1:0] ct, cc;
  logic             paired;

  assign syn    = stored ^ computed;
  assign lt     = syn[IDX_W-1:0];
  assign lc     = syn[2*IDX_W-1:IDX_W];
  assign ct     = syn[2*IDX_W+BIT_W-1:2*IDX_W];
  assign cc     = syn[ECC_W-1:2*IDX_W+BIT_W];
  assign paired = (&(lt ^ lc)) & (&(ct ^ cc));

  always_comb begin
    kind   = SYN_CLEAN;
    word   = '0;
    bitpos = '0;
    if (syn == '0) begin
      kind = SYN_CLEAN;
    end else if ($countones(syn) == 1) begin
      kind = SYN_CODE;
    end else if (paired) begin
      kind   = SYN_DATA;
      word   = lt;
      bitpos = ct;
    end else begin
      kind = SYN_MULTI;
    end
  end
endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc
  import nand_ecc_pkg::*;
#(
  parameter int  DATA_W         = 16,
  parameter int  MAX_PAGE_BYTES = 4096,
  localparam int IDX_W          = $clog2(MAX_PAGE_BYTES),
  localparam int BIT_W          = $clog2(DATA_W),
  localparam int ECC_W          = 2 * (IDX_W + BIT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_cs,
  input  logic              cfg_wide,
  input  logic [1:0]        cfg_page,
  input  logic              sw_clr,
  input  logic              chk_valid,
  input  logic [ECC_W-1:0]  chk_ecc,
  input  logic              stat_rd,
  output logic [ECC_W-1:0]  ecc_value,
  output logic              page_done,
  output logic              err_flag,
  output logic              corr_flag,
  output logic              ecc_err,
  output logic [IDX_W-1:0]  err_word,
  output logic [BIT_W-1:0]  err_bit
);
  localparam int MIN_BYTES = MAX_PAGE_BYTES / 8;

  logic             beat, last, commit, hold;
  logic [IDX_W-1:0] idx;
  logic [ECC_W-1:0] acc_next;
  syn_kind_e        kind;
  logic [IDX_W-1:0] dec_word;
  logic [BIT_W-1:0] dec_bit;

  assign bus_ready = 1'b1;
  assign beat      = bus_valid & bus_cs;
  assign commit    = beat & last & ~sw_clr;
  assign hold      = err_flag & ~stat_rd;

  nand_ecc_wordctr #(.IDX_W(IDX_W), .MIN_BYTES(MIN_BYTES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sw_clr(sw_clr),
    .cfg_page(cfg_page), .cfg_wide(cfg_wide), .idx(idx), .last(last)
  );

  nand_ecc_parity #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BIT_W(BIT_W), .ECC_W(ECC_W)) u_par (
    .clk(clk), .rst_n(rst_n), .beat(beat), .wrap(last), .sw_clr(sw_clr),
    .cfg_wide(cfg_wide), .data(bus_data), .idx(idx), .acc_next(acc_next)
  );

  nand_ecc_decode #(.IDX_W(IDX_W), .BIT_W(BIT_W), .ECC_W(ECC_W)) u_dec (
    .stored(chk_ecc), .computed(ecc_value), .kind(kind),
    .word(dec_word), .bitpos(dec_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecc_value <= '0;
      page_done <= 1'b0;
    end else begin
      if (commit) ecc_value <= acc_next;
      page_done <= commit | (page_done & ~stat_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag  <= 1'b0;
      corr_flag <= 1'b0;
      ecc_err   <= 1'b0;
      err_word  <= '0;
      err_bit   <= '0;
    end else if (!hold) begin
      if (chk_valid && kind != SYN_CLEAN) begin
        err_flag  <= 1'b1;
        corr_flag <= (kind != SYN_MULTI);
        ecc_err   <= (kind == SYN_CODE);
        err_word  <= dec_word;
        err_bit   <= dec_bit;
      end else begin
        err_flag  <= 1'b0;
        corr_flag <= 1'b0;
        ecc_err   <= 1'b0;
        err_word  <= '0;
        err_bit   <= '0;
      end
    end
  end
endmodule

// File: rtl/nand_ecc_chk.sv
module nand_ecc_chk #(
  parameter int IDX_W = 12,
  parameter int BIT_W = 4,
  parameter int ECC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_cs,
  input logic             chk_valid,
  input logic             stat_rd,
  input logic [ECC_W-1:0] ecc_value,
  input logic             page_done,
  input logic             err_flag,
  input logic             corr_flag,
  input logic             ecc_err,
  input logic [IDX_W-1:0] err_word,
  input logic [BIT_W-1:0] err_bit
);
  // R1
  cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_cs) |=> $stable(ecc_value));

  // R2
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_done) |-> $past(bus_valid && bus_cs));

  // R6
  clean_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_flag |-> (err_word == '0 && err_bit == '0 && !corr_flag));

  // R8
  code_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_err |-> (corr_flag && err_word == '0 && err_bit == '0));

  // R9
  corr_needs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    corr_flag |-> err_flag);

  // R10
  first_err_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !stat_rd) |=> (err_flag && $stable(err_word) && $stable(err_bit)));

  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !chk_valid) |=> !err_flag);
endmodule

bind nand_hamming_ecc nand_ecc_chk #(.IDX_W(IDX_W), .BIT_W(BIT_W), .ECC_W(ECC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_cs(bus_cs),
  .chk_valid(chk_valid), .stat_rd(stat_rd), .ecc_value(ecc_value),
  .page_done(page_done), .err_flag(err_flag), .corr_flag(corr_flag),
  .ecc_err(ecc_err), .err_word(err_word), .err_bit(err_bit)
);

// File: tb/tb_nand_hamming_ecc.sv
`timescale 1ns/1ps
module tb_nand_hamming_ecc;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_valid = 0, bus_cs = 0, cfg_wide = 0, sw_clr = 0, chk_valid = 0, stat_rd = 0;
  logic [15:0] bus_data = '0;
  logic [1:0]  cfg_page = '0;
  logic [31:0] chk_ecc = '0;
  logic        bus_ready, page_done, err_flag, corr_flag, ecc_err;
  logic [31:0] ecc_value;
  logic [11:0] err_word;
  logic [3:0]  err_bit;

  nand_hamming_ecc dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_data(bus_data), .bus_cs(bus_cs), .cfg_wide(cfg_wide), .cfg_page(cfg_page),
    .sw_clr(sw_clr), .chk_valid(chk_valid), .chk_ecc(chk_ecc), .stat_rd(stat_rd),
    .ecc_value(ecc_value), .page_done(page_done), .err_flag(err_flag),
    .corr_flag(corr_flag), .ecc_err(ecc_err), .err_word(err_word), .err_bit(err_bit)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit live = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          q[$];
  logic [31:0] m_ecc = '0;
  bit          m_done = 0, m_err = 0, m_corr = 0, m_code = 0;
  int          m_word = 0, m_bit = 0;

  function automatic logic [31:0] calc(input int ws[$]);
    int lt = 0, lc = 0, ct = 0, cc = 0;
    foreach (ws[w])
      for (int b = 0; b < 16; b++)
        if ((ws[w] >> b) & 1) begin
          for (int i = 0; i < 12; i++) if ((w >> i) & 1) lt ^= (1 << i); else lc ^= (1 << i);
          for (int j = 0; j < 4; j++)  if ((b >> j) & 1) ct ^= (1 << j); else cc ^= (1 << j);
        end
    return {4'(cc), 4'(ct), 12'(lc), 12'(lt)};
  endfunction

  task automatic decode(input logic [31:0] s);
    bit ok = 1;
    if (s == 0) return;
    m_err = 1;
    if ($countones(s) == 1) begin
      m_corr = 1; m_code = 1;
    end else begin
      for (int i = 0; i < 12; i++) if (s[i] == s[12+i]) ok = 0;
      for (int j = 0; j < 4; j++)  if (s[24+j] == s[28+j]) ok = 0;
      if (ok) begin m_corr = 1; m_word = int'(s[11:0]); m_bit = int'(s[27:24]); end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_ecc = '0; m_done = 0;
      m_err = 0; m_corr = 0; m_code = 0; m_word = 0; m_bit = 0;
    end else begin
      int words;
      words = (512 << cfg_page) >> cfg_wide;
      if (!(m_err && !stat_rd)) begin
        m_err = 0; m_corr = 0; m_code = 0; m_word = 0; m_bit = 0;
        if (chk_valid) decode(chk_ecc ^ m_ecc);
      end
      if (stat_rd) m_done = 0;
      if (sw_clr) q.delete();
      else if (bus_valid && bus_cs) begin
        q.push_back(cfg_wide ? int'(bus_data) : int'(bus_data[7:0]));
        if (q.size() == words) begin
          m_ecc = calc(q); q.delete(); m_done = 1;
        end
      end
    end
  end

  // per-cycle comparison (R3 code, R10 status)
  always @(negedge clk) if (live) begin
    check(ecc_value === m_ecc, "R3 per-cycle ecc_value", ecc_value, m_ecc);
    check({page_done, err_flag, corr_flag, ecc_err, err_word, err_bit} ===
          {m_done, m_err, m_corr, m_code, m_word[11:0], m_bit[3:0]},
          "R10 per-cycle status",
          {12'b0, page_done, err_flag, corr_flag, ecc_err, err_word, err_bit},
          {12'b0, m_done, m_err, m_corr, m_code, m_word[11:0], m_bit[3:0]});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog actual=%0d expected=<190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic put(input logic [15:0] d, input bit cs);
    bus_valid = 1; bus_cs = cs; bus_data = d;
    @(negedge clk);
    bus_valid = 0; bus_cs = 0; bus_data = '0;
  endtask

  task automatic pulse_clr();  sw_clr = 1;  @(negedge clk); sw_clr = 0;  endtask
  task automatic pulse_rd();   stat_rd = 1; @(negedge clk); stat_rd = 0; endtask
  task automatic do_chk(input logic [31:0] e);
    chk_valid = 1; chk_ecc = e; @(negedge clk); chk_valid = 0; chk_ecc = '0;
  endtask

  function automatic logic [15:0] pdata(input int seed, input int i);
    return 16'((i * 40503 + seed * 7919) ^ (i >> 2) ^ (seed << 5));
  endfunction

  task automatic page(input int seed, input int n, input int fw1, input int fb1,
                      input int fw2, input int fb2, input bit junk, input bit hi_noise);
    for (int i = 0; i < n; i++) begin
      logic [15:0] d;
      d = pdata(seed, i);
      if (hi_noise) d = d ^ 16'hA500;
      if (i == fw1) d = d ^ (16'h1 << fb1);
      if (i == fw2) d = d ^ (16'h1 << fb2);
      if (junk && (i % 61) == 5) put(~d, 1'b0);
      if ((i % 9) == 4) @(negedge clk);
      put(d, 1'b1);
    end
  endtask

  initial begin
    logic [31:0] good, g2, g3, g4;
    repeat (3) @(negedge clk);
    // R11 reset state
    check({ecc_value, page_done, err_flag, corr_flag, ecc_err} == 0, "R11 reset outputs",
          ecc_value, 32'h0);
    check({err_word, err_bit} == 0, "R11 reset error fields", {16'b0, err_word, err_bit}, 32'h0);
    rst_n = 1'b1;
    live = 1;
    @(negedge clk);

    // R3 explicit layout: 8-bit, 512 words, only word 5 = 0x01
    cfg_wide = 0; cfg_page = 0;
    for (int i = 0; i < 512; i++) put((i == 5) ? 16'h0001 : 16'h0000, 1'b1);
    check(ecc_value == 32'hF0FFA005, "R3 single-one page code", ecc_value, 32'hF0FFA005);
    check(page_done == 1'b1, "R2 page_done after last word", {31'b0, page_done}, 32'h1);
    pulse_rd();
    check(page_done == 1'b0, "R10 page_done cleared by read", {31'b0, page_done}, 32'h0);

    // clean reference page, then the same page with cs-low junk words
    page(1, 512, -1, 0, -1, 0, 0, 0);
    good = ecc_value;
    page(1, 512, -1, 0, -1, 0, 1, 0);
    check(ecc_value == good, "R1 cs-low words ignored", ecc_value, good);

    do_chk(good);
    check(err_flag == 0 && corr_flag == 0, "R6 clean check", {30'b0, err_flag, corr_flag}, 32'h0);

    // R7 single data bit
    page(1, 512, 100, 5, -1, 0, 0, 0);
    do_chk(good);
    check(err_flag && corr_flag && !ecc_err && err_word == 100 && err_bit == 5,
          "R7 single data bit", {err_flag, corr_flag, ecc_err, 1'b0, 8'b0, err_word, err_bit},
          {4'hC, 8'b0, 12'd100, 4'd5});
    pulse_rd();
    check(err_flag == 0, "R10 flags cleared by read", {31'b0, err_flag}, 32'h0);

    // R8 error in the stored code, then R10 hold against a later data error
    page(1, 512, -1, 0, -1, 0, 0, 0);
    do_chk(good ^ 32'h0000_2000);
    check(err_flag && corr_flag && ecc_err && err_word == 0 && err_bit == 0,
          "R8 code bit error", {28'b0, err_flag, corr_flag, ecc_err, |{err_word, err_bit}}, 32'hE);
    page(1, 512, 7, 2, -1, 0, 0, 0);
    do_chk(good);
    check(ecc_err && err_word == 0, "R10 first error held", {19'b0, ecc_err, err_word}, 32'h1000);
    pulse_rd();

    // R9 two data bits
    page(1, 512, 3, 1, 40, 6, 0, 0);
    do_chk(good);
    check(err_flag && !corr_flag, "R9 double error", {30'b0, err_flag, corr_flag}, 32'h2);
    pulse_rd();

    // R4 upper byte ignored in 8-bit mode
    page(1, 512, -1, 0, -1, 0, 0, 1);
    check(ecc_value == good, "R4 upper byte ignored", ecc_value, good);

    // R2 wrap into next page, then R5 clear of the partial page
    page(1, 522, -1, 0, -1, 0, 0, 0);
    check(ecc_value == good, "R2 wrap keeps first page code", ecc_value, good);
    pulse_clr();
    page(1, 512, -1, 0, -1, 0, 0, 0);
    check(ecc_value == good && page_done, "R5 partial page discarded", ecc_value, good);
    pulse_rd();

    // 16-bit, 1024 bytes
    cfg_wide = 1; cfg_page = 1;
    page(2, 512, -1, 0, -1, 0, 0, 0);
    g2 = ecc_value;
    page(2, 512, 300, 13, -1, 0, 0, 0);
    do_chk(g2);
    check(corr_flag && err_word == 300 && err_bit == 13, "R4 16-bit data bit 13",
          {15'b0, corr_flag, err_word, err_bit}, {15'b0, 1'b1, 12'd300, 4'd13});
    pulse_rd();

    // 16-bit, 4096 bytes, last word, top bit
    cfg_page = 3;
    page(3, 2048, -1, 0, -1, 0, 0, 0);
    g3 = ecc_value;
    page(3, 2048, 2047, 15, -1, 0, 0, 0);
    do_chk(g3);
    check(corr_flag && err_word == 2047 && err_bit == 15, "R7 last word of 16-bit page",
          {15'b0, corr_flag, err_word, err_bit}, {15'b0, 1'b1, 12'd2047, 4'd15});
    pulse_rd();

    // 8-bit, 4096 bytes, last word
    cfg_wide = 0;
    page(4, 4096, -1, 0, -1, 0, 0, 0);
    g4 = ecc_value;
    page(4, 4096, 4095, 7, -1, 0, 0, 0);
    do_chk(g4);
    check(corr_flag && err_word == 4095 && err_bit == 7, "R7 last word of 8-bit page",
          {15'b0, corr_flag, err_word, err_bit}, {15'b0, 1'b1, 12'd4095, 4'd7});
    pulse_rd();
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule